// File: doc/BRIEF.md
# Return Address Predictor Stack with Fetch-Mode Bit

This block keeps a small last-in, first-out store of predicted subroutine return targets for a fetch unit. When the front end recognises a call, it presents the return address (the value written to the link register) and a single bit that records which instruction encoding the caller was running in. The value 0 means fixed 32-bit encoding and 1 means the compact mixed 16/32-bit encoding. When a return is predicted taken, the fetch unit takes the top address and mode from the outputs and asks for a pop. A predicted return therefore redirects both the fetch address and the decode mode.

The store holds eight entries by default. It behaves as a ring, so a call chain deeper than the store keeps the newest entries and loses the oldest. The top entry is always visible on the outputs, together with a flag that says whether it is valid. A flush input discards every entry at once, for example after a pipeline redirect. Detecting calls and returns, and repairing the stack after a misprediction, are done elsewhere.

Top module: `ras_mode_stack`

## Requirements
- R1: While reset is asserted and after it is released, `top_valid`, `top_addr` and `top_mode` read 0.
- R2: One clock after a push, `top_valid` is 1 and `top_addr`/`top_mode` equal the pushed address and mode bit.
- R3: Pops return entries newest first. One clock after a pop, the outputs show the entry that was pushed before the popped one.
- R4: Capacity is DEPTH (8) entries. After more than DEPTH pushes, the stack keeps the last DEPTH values, and exactly DEPTH pops empty it.
- R5: A pop while the stack is empty leaves `top_valid` at 0 and changes no stored state. A later single push followed by a single pop empties the stack again.
- R6: A push and a pop in the same cycle on a non-empty stack replace the top entry with the pushed value and keep the depth. The next pop exposes the entry that was below the old top.
- R7: One clock after `flush` is 1, the stack is empty (`top_valid` = 0). Flush takes priority over a push or pop in the same cycle.
- R8: Whenever `top_valid` is 0, `top_addr` and `top_mode` are driven to 0.
- R9: A push and a pop in the same cycle on an empty stack act as a plain push, which leaves depth 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard all entries |
| push_valid | input | 1 | Push the address and mode below |
| push_addr | input | ADDR_W | Return address to push |
| push_mode | input | 1 | Caller encoding mode (0 = 32-bit, 1 = compact) |
| pop_req | input | 1 | Remove the top entry |
| top_valid | output | 1 | Top entry is valid |
| top_addr | output | ADDR_W | Predicted return address |
| top_mode | output | 1 | Predicted return encoding mode |

## Verification
A push and a pop can arrive in the same cycle. Then the top entry has to be replaced in place, and neither a push nor a pop may take effect on its own. The bench drives this combination directly on a partly filled stack and on an empty one. It also produces the combination often in the random phase, where push and pop requests are drawn independently. A reference queue in the bench judges each case by applying the replace-or-push rule. The pop that follows a replacement must then reveal the entry that was below, and the depth must be unchanged.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PUSH      = 3'd1,
    OP_POP       = 3'd2,
    OP_SWAP      = 3'd3,
    OP_FLUSH     = 3'd4,
    OP_EMPTY_POP = 3'd5
  } ras_op_e;

  // Priority: flush, then push+pop on a non-empty stack, then push, then pop.
  function automatic ras_op_e ras_decode(input logic flush, input logic push,
                                         input logic pop, input logic nonempty);
    ras_op_e op;
    if (flush)                      op = OP_FLUSH;
    else if (push && pop && nonempty) op = OP_SWAP;
    else if (push)                  op = OP_PUSH;
    else if (pop && nonempty)       op = OP_POP;
    else if (pop)                   op = OP_EMPTY_POP;
    else                            op = OP_IDLE;
    return op;
  endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ras_op_e          op,
  output logic [IDX_W-1:0] tos,
  output logic [CNT_W-1:0] depth_cnt,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             ev_overflow,
  output logic             ev_underflow
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  function automatic logic [IDX_W-1:0] idx_up(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_down(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_up_sat(input logic [CNT_W-1:0] c);
    return (c == FULL_CNT) ? c : c + 1'b1;
  endfunction

  logic [IDX_W-1:0] tos_n;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    tos_n  = tos;
    cnt_n  = depth_cnt;
    wr_en  = 1'b0;
    wr_idx = tos;
    unique case (op)
      OP_PUSH: begin
        wr_en  = 1'b1;
        wr_idx = idx_up(tos);
        tos_n  = idx_up(tos);
        cnt_n  = cnt_up_sat(depth_cnt);
      end
      OP_SWAP: begin
        wr_en  = 1'b1;
        wr_idx = tos;
      end
      OP_POP: begin
        tos_n = idx_down(tos);
        cnt_n = depth_cnt - 1'b1;
      end
      OP_FLUSH: begin
        tos_n = '0;
        cnt_n = '0;
      end
      default: ;
    endcase
  end

  assign ev_overflow  = (op == OP_PUSH) && (depth_cnt == FULL_CNT);
  assign ev_underflow = (op == OP_EMPTY_POP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos       <= '0;
      depth_cnt <= '0;
    end else begin
      tos       <= tos_n;
      depth_cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_mode,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_mode
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic              slot_mode [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[g] <= '0;
        slot_mode[g] <= 1'b0;
      end else if (hit) begin
        slot_addr[g] <= wr_addr;
        slot_mode[g] <= wr_mode;
      end
    end
  end

  assign rd_addr = slot_addr[rd_idx];
  assign rd_mode = slot_mode[rd_idx];

endmodule

// File: rtl/ras_mode_stack.sv
module ras_mode_stack
  import ras_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push_valid,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              push_mode,
  input  logic              pop_req,
  output logic              top_valid,
  output logic [ADDR_W-1:0] top_addr,
  output logic              top_mode
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ras_op_e          op;
  logic [IDX_W-1:0] tos;
  logic [CNT_W-1:0] depth_cnt;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             ev_overflow;
  logic             ev_underflow;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_mode;
  logic              nonempty;

  assign nonempty = (depth_cnt != '0);
  assign op       = ras_decode(flush, push_valid, pop_req, nonempty);

  ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (op),
    .tos          (tos),
    .depth_cnt    (depth_cnt),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .ev_overflow  (ev_overflow),
    .ev_underflow (ev_underflow)
  );

  ras_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_addr (push_addr),
    .wr_mode (push_mode),
    .rd_idx  (tos),
    .rd_addr (rd_addr),
    .rd_mode (rd_mode)
  );

  assign top_valid = nonempty;
  assign top_addr  = nonempty ? rd_addr : '0;
  assign top_mode  = nonempty && rd_mode;

endmodule

// File: rtl/ras_mode_stack_chk.sv
module ras_mode_stack_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              push_valid,
  input logic [ADDR_W-1:0] push_addr,
  input logic              push_mode,
  input logic              pop_req,
  input logic              top_valid,
  input logic [ADDR_W-1:0] top_addr,
  input logic              top_mode,
  input logic [CNT_W-1:0]  depth_cnt,
  input logic              ev_overflow,
  input logic              ev_underflow
);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!top_valid && top_addr == '0 && !top_mode);
    end
  end

  // R2
  push_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !flush) |=> (top_valid && top_addr == $past(push_addr)
                                && top_mode == $past(push_mode)));

  // R3
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && !flush && top_valid)
      |=> (depth_cnt == $past(depth_cnt) - 1'b1));

  // R4
  overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (depth_cnt == CNT_W'(DEPTH)));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_cnt <= CNT_W'(DEPTH));

  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underflow |=> !top_valid);

  // R6
  swap_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req && !flush && top_valid) |=> $stable(depth_cnt));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !top_valid);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (top_addr == '0 && !top_mode));

  // R9
  swap_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req && !flush && !top_valid) |=> (depth_cnt == CNT_W'(1)));

endmodule

bind ras_mode_stack ras_mode_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .push_valid   (push_valid),
  .push_addr    (push_addr),
  .push_mode    (push_mode),
  .pop_req      (pop_req),
  .top_valid    (top_valid),
  .top_addr     (top_addr),
  .top_mode     (top_mode),
  .depth_cnt    (depth_cnt),
  .ev_overflow  (ev_overflow),
  .ev_underflow (ev_underflow)
);

// File: tb/sim_ras_mode_stack.sv
`timescale 1ns/1ps
module sim_ras_mode_stack;

  localparam int DEPTH  = 8;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              push_valid = 1'b0;
  logic [ADDR_W-1:0] push_addr = '0;
  logic              push_mode = 1'b0;
  logic              pop_req = 1'b0;
  logic              top_valid;
  logic [ADDR_W-1:0] top_addr;
  logic              top_mode;

  always #2.5 clk = ~clk;

  ras_mode_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .push_addr(push_addr), .push_mode(push_mode), .pop_req(pop_req),
    .top_valid(top_valid), .top_addr(top_addr), .top_mode(top_mode)
  );

  typedef struct { logic [ADDR_W-1:0] a; logic m; } ent_t;
  ent_t ref_q[$];

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic logic exp_valid();
    return ref_q.size() != 0;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr();
    return (ref_q.size() != 0) ? ref_q[ref_q.size()-1].a : '0;
  endfunction

  function automatic logic exp_mode();
    return (ref_q.size() != 0) ? ref_q[ref_q.size()-1].m : 1'b0;
  endfunction

  // Reference rule: flush wins; push+pop on non-empty replaces the newest;
  // push appends and drops the oldest beyond DEPTH; pop on empty does nothing.
  function automatic void ref_apply(logic f, logic pu, logic [ADDR_W-1:0] a,
                                    logic m, logic po);
    ent_t e;
    e.a = a; e.m = m;
    if (f) ref_q.delete();
    else if (pu && po && ref_q.size() != 0) ref_q[ref_q.size()-1] = e;
    else if (pu) begin
      ref_q.push_back(e);
      if (ref_q.size() > DEPTH) void'(ref_q.pop_front());
    end else if (po && ref_q.size() != 0) void'(ref_q.pop_back());
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (top_valid !== exp_valid() || top_addr !== exp_addr() || top_mode !== exp_mode()) begin
      miscompares++;
      $display("FAIL %s: got valid=%0b addr=%h mode=%0b, expected valid=%0b addr=%h mode=%0b",
               tag, top_valid, top_addr, top_mode, exp_valid(), exp_addr(), exp_mode());
    end
  endtask

  // Called at a falling edge: drive, update reference, wait one cycle, compare.
  task automatic step(logic f, logic pu, logic [ADDR_W-1:0] a, logic m,
                      logic po, string tag);
    flush = f; push_valid = pu; push_addr = a; push_mode = m; pop_req = po;
    ref_apply(f, pu, a, m, po);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R5: pop while empty
    step(0, 0, '0, 0, 1, "R5 empty pop");
    step(0, 0, '0, 0, 1, "R5 empty pop again");
    // R9: push+pop on empty
    step(0, 1, 32'hCAFE_0010, 1, 1, "R9 swap on empty");
    step(0, 0, '0, 0, 1, "R9 single pop empties");
    // R5: push then pop after underflow
    step(0, 1, 32'h0000_4000, 0, 0, "R2 push");
    step(0, 0, '0, 0, 1, "R5 pop back to empty");

    // R4: overflow by pushing DEPTH+2 values, then drain
    for (int i = 0; i < DEPTH + 2; i++)
      step(0, 1, 32'h1000_0000 + 32'(i * 4), 1'(i & 1), 0, "R2 push fill");
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, '0, 0, 1, "R4 drain newest first R3");
    step(0, 0, '0, 0, 1, "R4 empty after DEPTH pops");

    // R6: swap on partly filled stack
    step(0, 1, 32'h2000_0000, 0, 0, "R2 push a");
    step(0, 1, 32'h2000_0004, 1, 0, "R2 push b");
    step(0, 1, 32'h2000_0F00, 0, 1, "R6 swap replaces top");
    step(0, 0, '0, 0, 1, "R6 pop reveals below");
    step(0, 0, '0, 0, 1, "R3 pop to empty R8");

    // R7: flush with simultaneous push and pop
    step(0, 1, 32'h3000_0000, 1, 0, "R2 push");
    step(0, 1, 32'h3000_0004, 0, 0, "R2 push");
    step(1, 1, 32'h3000_0008, 1, 1, "R7 flush wins");
    step(0, 0, '0, 0, 1, "R7 stays empty R8");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic f, pu, po;
      f  = ($urandom % 40) == 0;
      pu = ($urandom % 100) < 50;
      po = ($urandom % 100) < 45;
      step(f, pu, $urandom, 1'($urandom), po, "R3 R6 random");
    end

    step(1, 0, '0, 0, 0, "R7 final flush");
    done = 1;
    summary();
    $finish;
  end

endmodule